// File: doc/BRIEF.md
# Indirect Target Predictor Update Controller

This block trains an indirect-jump target predictor made of several tagged tables. Table 0 uses the shortest history and table `NT-1` the longest. When a resolved update is presented, the controller reads three things: what the predictor saw at prediction time (the provider and alternate hits, their table numbers, confidence counters, useful bit and stored targets), the resolved target, and whether the final prediction was wrong. From these it issues registered write commands for the provider entry, the alternate entry and, when needed, a freshly allocated entry in a longer-history table. The index and tag hashing and the storage arrays live outside this block. The controller only emits a table number and the field values to write.

When the provider's counter is 0 it is weak, and the final target came from the alternate. That is the second-longest hit, or the base target supplied by the upstream predictor when no second table hit. When the provider is confident and still wrong, the controller tries to allocate a new entry. The outcome of each attempt moves an 8-bit tick counter: a failed attempt raises it and a successful one lowers it. When the counter climbs to its top value it returns to 0 and orders every useful bit in the predictor to be cleared.

Top module: `itgt_trainer`

## Requirements
- R1: No write command is issued and the tick counter does not change when `upd_valid` is low, or when `upd_indirect` is low.
- R2: On an active update with a provider hit, the provider write command is always issued. Its counter is incremented when the provider's target equals the resolved target, and it holds at 3.
- R3: On an active update, when the provider's target differs from the resolved target, the provider counter is decremented and holds at 0.
- R4: An entry's written target is the resolved target when that entry's counter was 0 at prediction time. Otherwise the written target is the stored target unchanged.
- R5: The alternate write command is issued only when the provider counter was 0 and an alternate table hit. Its counter rises when the alternate target is correct and falls when it is wrong, saturating at 0 and 3, and its target follows R4.
- R6: When the provider counter was non-zero, the written provider useful bit is 1 if the provider was correct and the alternate was wrong. Otherwise it keeps its stored value. The alternate means the alternate target on an alternate hit, and the base target without one.
- R7: When the provider counter was 0, the written provider useful bit equals the correctness of the alternate: the alternate target on an alternate hit, the base target otherwise.
- R8: An active update whose provider was confident and whose final prediction was wrong (`upd_mispred`=1) attempts an allocation. The allocation targets a table with a number greater than the provider's whose `free_mask` bit is 1 (bit i for table i). The new entry is written with the resolved target, counter 0 and useful bit 0. The choice among several eligible tables is pseudo-random.
- R9: A failed allocation attempt (no eligible table) raises the tick counter by 1. A successful one lowers it by 1, holding at 0.
- R10: When a failure would bring the tick counter to 255, the counter becomes 0 instead and `u_clear` pulses high for one cycle.
- R11: All commands appear on the outputs one clock after the update is sampled and last a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update present this cycle |
| upd_indirect | input | 1 | Updated slot is an indirect jump |
| upd_mispred | input | 1 | Final prediction was wrong |
| act_tgt | input | TW | Resolved target |
| base_tgt | input | TW | Base (upstream) target used when no alternate hit |
| prov_hit | input | 1 | A tagged table provided |
| prov_tbl | input | TBW | Provider table number |
| prov_ctr | input | CW | Provider counter at prediction |
| prov_u | input | 1 | Provider useful bit at prediction |
| prov_tgt | input | TW | Provider stored target |
| alt_hit | input | 1 | A second tagged table hit |
| alt_tbl | input | TBW | Alternate table number |
| alt_ctr | input | CW | Alternate counter at prediction |
| alt_tgt | input | TW | Alternate stored target |
| free_mask | input | NT | Per table: indexed entry has useful bit 0 |
| prov_we | output | 1 | Provider write command |
| prov_tbl_o | output | TBW | Provider table to write |
| prov_ctr_o | output | CW | Provider counter value |
| prov_tgt_o | output | TW | Provider target value |
| prov_u_o | output | 1 | Provider useful bit value |
| alt_we | output | 1 | Alternate write command |
| alt_tbl_o | output | TBW | Alternate table to write |
| alt_ctr_o | output | CW | Alternate counter value |
| alt_tgt_o | output | TW | Alternate target value |
| alloc_we | output | 1 | Allocation write (sets tag valid) |
| alloc_tbl_o | output | TBW | Table receiving the new entry |
| alloc_tgt_o | output | TW | New entry target |
| alloc_ctr_o | output | CW | New entry counter |
| alloc_u_o | output | 1 | New entry useful bit |
| u_clear | output | 1 | Clear every useful bit |
| tick_o | output | KW | Tick counter value |

## Verification
The bench drives both counters into their saturation limits. A design that wrapped would turn a confident counter weak, or a weak one confident. It checks that targets are rewritten only at counter 0. A design that always overwrote would erase a confident target on a single miss. Allocation masks are given eligible bits below the provider as well as above it. This exposes a design that allocates into a shorter table or ignores the free flags. The tick counter is driven into its lower limit by successes and then up to the 255 boundary by failures, so an off-by-one in the clear or a missing reset to 0 shows directly on `u_clear` and `tick_o`.

// File: rtl/itgt_trainer.sv
module itgt_trainer #(
  parameter int NT = 5,
  parameter int TW = 41,
  parameter int CW = 2,
  parameter int KW = 8,
  parameter int LW = 8,
  parameter logic [LW-1:0] LTAPS = 8'hB8,
  localparam int TBW = $clog2(NT),
  localparam int CMAX = (1 << CW) - 1,
  localparam int KMAX = (1 << KW) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_valid,
  input  logic           upd_indirect,
  input  logic           upd_mispred,
  input  logic [TW-1:0]  act_tgt,
  input  logic [TW-1:0]  base_tgt,
  input  logic           prov_hit,
  input  logic [TBW-1:0] prov_tbl,
  input  logic [CW-1:0]  prov_ctr,
  input  logic           prov_u,
  input  logic [TW-1:0]  prov_tgt,
  input  logic           alt_hit,
  input  logic [TBW-1:0] alt_tbl,
  input  logic [CW-1:0]  alt_ctr,
  input  logic [TW-1:0]  alt_tgt,
  input  logic [NT-1:0]  free_mask,
  output logic           prov_we,
  output logic [TBW-1:0] prov_tbl_o,
  output logic [CW-1:0]  prov_ctr_o,
  output logic [TW-1:0]  prov_tgt_o,
  output logic           prov_u_o,
  output logic           alt_we,
  output logic [TBW-1:0] alt_tbl_o,
  output logic [CW-1:0]  alt_ctr_o,
  output logic [TW-1:0]  alt_tgt_o,
  output logic           alloc_we,
  output logic [TBW-1:0] alloc_tbl_o,
  output logic [TW-1:0]  alloc_tgt_o,
  output logic [CW-1:0]  alloc_ctr_o,
  output logic           alloc_u_o,
  output logic           u_clear,
  output logic [KW-1:0]  tick_o
);

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic up);
    if (up) return (c == CW'(CMAX)) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic act, p_weak, p_ok, a_ok, a_used, try_alloc, any_elig;
  logic [NT-1:0]  longer, elig;
  logic [LW-1:0]  lfsr, rmod;
  logic [TBW-1:0] sel;

  assign act       = upd_valid & upd_indirect;
  assign p_weak    = (prov_ctr == '0);
  assign p_ok      = (prov_tgt == act_tgt);
  assign a_ok      = alt_hit ? (alt_tgt == act_tgt) : (base_tgt == act_tgt);
  assign a_used    = prov_hit & p_weak;
  assign try_alloc = act & prov_hit & ~p_weak & upd_mispred;

  for (genvar g = 0; g < NT; g++) begin : g_longer
    assign longer[g] = (TBW'(g) > prov_tbl);
  end
  assign elig     = free_mask & longer;
  assign any_elig = |elig;
  assign rmod     = lfsr % LW'(NT);

  always_comb begin
    sel = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (elig[i]) sel = TBW'(i);
    if (rmod < LW'(NT) && elig[rmod[TBW-1:0]]) sel = rmod[TBW-1:0];
  end

  assign alloc_ctr_o = '0;
  assign alloc_u_o   = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr        <= LW'(1);
      prov_we     <= 1'b0;
      prov_tbl_o  <= '0;
      prov_ctr_o  <= '0;
      prov_tgt_o  <= '0;
      prov_u_o    <= 1'b0;
      alt_we      <= 1'b0;
      alt_tbl_o   <= '0;
      alt_ctr_o   <= '0;
      alt_tgt_o   <= '0;
      alloc_we    <= 1'b0;
      alloc_tbl_o <= '0;
      alloc_tgt_o <= '0;
      u_clear     <= 1'b0;
      tick_o      <= '0;
    end else begin
      lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LTAPS) : (lfsr >> 1);

      prov_we    <= act & prov_hit;
      prov_tbl_o <= prov_tbl;
      prov_ctr_o <= step(prov_ctr, p_ok);
      prov_tgt_o <= p_weak ? act_tgt : prov_tgt;
      prov_u_o   <= a_used ? a_ok : ((p_ok & ~a_ok) | prov_u);

      alt_we    <= act & a_used & alt_hit;
      alt_tbl_o <= alt_tbl;
      alt_ctr_o <= step(alt_ctr, alt_tgt == act_tgt);
      alt_tgt_o <= (alt_ctr == '0) ? act_tgt : alt_tgt;

      alloc_we    <= try_alloc & any_elig;
      alloc_tbl_o <= sel;
      alloc_tgt_o <= act_tgt;

      u_clear <= 1'b0;
      if (try_alloc) begin
        if (any_elig) begin
          if (tick_o != '0) tick_o <= tick_o - 1'b1;
        end else if (tick_o == KW'(KMAX - 1)) begin
          tick_o  <= '0;
          u_clear <= 1'b1;
        end else begin
          tick_o <= tick_o + 1'b1;
        end
      end
    end
  end

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_indirect) |=> !prov_we && !alt_we && !alloc_we);
  // R8
  alloc_longer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> prov_we && (alloc_tbl_o > prov_tbl_o));
  // R8
  alloc_alt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> !alt_we);
  // R3
  alloc_ctr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> prov_ctr_o != CW'(CMAX));
  // R5
  alt_weak_prov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_we |-> prov_we && prov_ctr_o <= CW'(1));
  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_clear |-> tick_o == '0);
  // R9
  tick_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o != KW'(KMAX));
  // R10
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_clear |=> !u_clear);

endmodule

// File: tb/test_itgt_trainer.sv
`timescale 1ns/1ps
module test_itgt_trainer;
  localparam int NT = 5, TW = 41, CW = 2, KW = 8, TBW = 3;

  logic clk = 0, rst_n = 0;
  logic upd_valid = 0, upd_indirect = 0, upd_mispred = 0;
  logic [TW-1:0] act_tgt = '0, base_tgt = '0, prov_tgt = '0, alt_tgt = '0;
  logic prov_hit = 0, prov_u = 0, alt_hit = 0;
  logic [TBW-1:0] prov_tbl = '0, alt_tbl = '0;
  logic [CW-1:0] prov_ctr = '0, alt_ctr = '0;
  logic [NT-1:0] free_mask = '0;
  logic prov_we, prov_u_o, alt_we, alloc_we, alloc_u_o, u_clear;
  logic [TBW-1:0] prov_tbl_o, alt_tbl_o, alloc_tbl_o;
  logic [CW-1:0] prov_ctr_o, alt_ctr_o, alloc_ctr_o;
  logic [TW-1:0] prov_tgt_o, alt_tgt_o, alloc_tgt_o;
  logic [KW-1:0] tick_o;

  int checks = 0, failures = 0, exp_tick = 0;

  always #2.5 clk = ~clk;

  itgt_trainer i_itgt_trainer (
    .clk, .rst_n, .upd_valid, .upd_indirect, .upd_mispred, .act_tgt, .base_tgt,
    .prov_hit, .prov_tbl, .prov_ctr, .prov_u, .prov_tgt, .alt_hit, .alt_tbl,
    .alt_ctr, .alt_tgt, .free_mask, .prov_we, .prov_tbl_o, .prov_ctr_o,
    .prov_tgt_o, .prov_u_o, .alt_we, .alt_tbl_o, .alt_ctr_o, .alt_tgt_o,
    .alloc_we, .alloc_tbl_o, .alloc_tgt_o, .alloc_ctr_o, .alloc_u_o,
    .u_clear, .tick_o);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic setp(input logic h, input int t, input int c, input logic u, input logic [TW-1:0] tg);
    prov_hit = h; prov_tbl = TBW'(t); prov_ctr = CW'(c); prov_u = u; prov_tgt = tg;
  endtask

  task automatic seta(input logic h, input int t, input int c, input logic [TW-1:0] tg);
    alt_hit = h; alt_tbl = TBW'(t); alt_ctr = CW'(c); alt_tgt = tg;
  endtask

  // drive one update at a falling edge; return at the next falling edge
  task automatic fire(input logic v, input logic ind, input logic mis,
                      input logic [TW-1:0] at, input logic [TW-1:0] bt, input logic [NT-1:0] m);
    logic [NT-1:0] lg;
    upd_valid = v; upd_indirect = ind; upd_mispred = mis;
    act_tgt = at; base_tgt = bt; free_mask = m;
    lg = '0;
    for (int i = 0; i < NT; i++) if (i > int'(prov_tbl)) lg[i] = 1'b1;
    if (v && ind && prov_hit && prov_ctr != 0 && mis) begin
      if ((m & lg) != 0) begin
        if (exp_tick > 0) exp_tick--;
      end else begin
        exp_tick++;
        if (exp_tick == 255) exp_tick = 0;
      end
    end
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset prov_we", prov_we, 0);
    chk("R11 reset alloc_we", alloc_we, 0);
    chk("R10 reset tick", tick_o, 0);
  endtask

  task automatic t_inactive;
    setp(1, 2, 2, 0, 41'h111); seta(0, 0, 0, 0);
    fire(0, 1, 1, 41'h222, 0, 5'b11111);
    chk("R1 valid low prov_we", prov_we, 0);
    chk("R1 valid low alloc_we", alloc_we, 0);
    chk("R1 valid low tick", tick_o, 0);
    fire(1, 0, 1, 41'h222, 0, 5'b00000);
    chk("R1 not indirect prov_we", prov_we, 0);
    chk("R1 not indirect tick", tick_o, 0);
  endtask

  task automatic t_inc;
    setp(1, 2, 1, 0, 41'h1234); seta(0, 0, 0, 0);
    fire(1, 1, 0, 41'h1234, 41'h9, 0);
    chk("R2 prov_we", prov_we, 1);
    chk("R2 prov tbl", prov_tbl_o, 2);
    chk("R2 ctr 1->2", prov_ctr_o, 2);
    chk("R4 confident keeps tgt", prov_tgt_o, 41'h1234);
    chk("R11 one cycle later", prov_we, 1);
    @(negedge clk);
    chk("R11 single cycle pulse", prov_we, 0);
    setp(1, 3, 3, 1, 41'h55);
    fire(1, 1, 0, 41'h55, 0, 0);
    chk("R2 ctr saturates at 3", prov_ctr_o, 3);
  endtask

  task automatic t_dec;
    setp(1, 4, 2, 0, 41'hAAA); seta(0, 0, 0, 0);
    fire(1, 1, 1, 41'hBBB, 0, 5'b01111);
    chk("R3 ctr 2->1", prov_ctr_o, 1);
    chk("R4 confident wrong keeps tgt", prov_tgt_o, 41'hAAA);
    chk("R9 failed alloc tick", tick_o, exp_tick);
    chk("R8 no longer table no alloc", alloc_we, 0);
    setp(1, 1, 0, 0, 41'hAAA);
    fire(1, 1, 1, 41'hCCC, 41'h0, 5'b11111);
    chk("R3 ctr holds at 0", prov_ctr_o, 0);
    chk("R4 weak overwrites tgt", prov_tgt_o, 41'hCCC);
    chk("R8 weak provider no alloc", alloc_we, 0);
    chk("R9 weak provider tick unchanged", tick_o, exp_tick);
  endtask

  task automatic t_alt;
    setp(1, 3, 0, 0, 41'h10); seta(1, 1, 0, 41'h20);
    fire(1, 1, 0, 41'h20, 41'h0, 0);
    chk("R5 alt_we", alt_we, 1);
    chk("R5 alt tbl", alt_tbl_o, 1);
    chk("R5 alt ctr 0->1", alt_ctr_o, 1);
    chk("R5 alt weak tgt overwrite", alt_tgt_o, 41'h20);
    seta(1, 0, 2, 41'h30);
    fire(1, 1, 1, 41'h31, 41'h0, 0);
    chk("R5 alt ctr 2->1", alt_ctr_o, 1);
    chk("R5 alt confident keeps tgt", alt_tgt_o, 41'h30);
    seta(1, 0, 3, 41'h31);
    fire(1, 1, 0, 41'h31, 41'h0, 0);
    chk("R5 alt ctr saturates 3", alt_ctr_o, 3);
    seta(0, 0, 0, 0);
    fire(1, 1, 0, 41'h31, 41'h31, 0);
    chk("R5 no alt hit no alt_we", alt_we, 0);
    setp(1, 3, 2, 0, 41'h31); seta(1, 1, 0, 41'h40);
    fire(1, 1, 0, 41'h31, 41'h0, 0);
    chk("R5 confident provider no alt_we", alt_we, 0);
  endtask

  task automatic t_useful;
    setp(1, 2, 2, 0, 41'h77); seta(1, 0, 1, 41'h66);
    fire(1, 1, 0, 41'h77, 41'h0, 0);
    chk("R6 prov right alt wrong sets u", prov_u_o, 1);
    seta(1, 0, 1, 41'h77);
    fire(1, 1, 0, 41'h77, 41'h0, 0);
    chk("R6 both right keeps u=0", prov_u_o, 0);
    setp(1, 2, 2, 1, 41'h77); seta(0, 0, 0, 0);
    fire(1, 1, 0, 41'h77, 41'h77, 0);
    chk("R6 base right keeps u=1", prov_u_o, 1);
    setp(1, 2, 0, 0, 41'h1); seta(1, 0, 1, 41'h88);
    fire(1, 1, 0, 41'h88, 41'h0, 0);
    chk("R7 weak alt right sets u", prov_u_o, 1);
    setp(1, 2, 0, 1, 41'h88); seta(1, 0, 1, 41'h99);
    fire(1, 1, 1, 41'h88, 41'h0, 0);
    chk("R7 weak alt wrong clears u", prov_u_o, 0);
    setp(1, 2, 0, 0, 41'h1); seta(0, 0, 0, 0);
    fire(1, 1, 0, 41'h5, 41'h5, 0);
    chk("R7 base right sets u", prov_u_o, 1);
  endtask

  task automatic t_alloc;
    setp(1, 1, 2, 1, 41'hF0); seta(0, 0, 0, 0);
    fire(1, 1, 1, 41'hF1, 0, 5'b01011);
    chk("R8 alloc_we", alloc_we, 1);
    chk("R8 only longer free table", alloc_tbl_o, 3);
    chk("R8 new tgt", alloc_tgt_o, 41'hF1);
    chk("R8 new ctr 0", alloc_ctr_o, 0);
    chk("R8 new u 0", alloc_u_o, 0);
    chk("R9 success tick", tick_o, exp_tick);
    for (int k = 0; k < 6; k++) begin
      fire(1, 1, 1, 41'hF2, 0, 5'b10100);
      chk("R8 pick within eligible", (alloc_tbl_o == 2 || alloc_tbl_o == 4) && alloc_we, 1);
      chk("R9 success saturates at 0", tick_o, exp_tick);
    end
    fire(1, 1, 0, 41'hF2, 0, 5'b11111);
    chk("R8 no mispred no alloc", alloc_we, 0);
  endtask

  task automatic t_tick;
    setp(1, 4, 3, 0, 41'h3); seta(0, 0, 0, 0);
    while (exp_tick < 254) fire(1, 1, 1, 41'h4, 0, 5'b11111);
    chk("R9 tick climbs to 254", tick_o, 254);
    chk("R10 no clear before top", u_clear, 0);
    fire(1, 1, 1, 41'h4, 0, 5'b11111);
    chk("R10 clear pulse", u_clear, 1);
    chk("R10 tick back to 0", tick_o, 0);
    @(negedge clk);
    chk("R10 clear lasts one cycle", u_clear, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_inactive;
    t_inc;
    t_dec;
    t_alt;
    t_useful;
    t_alloc;
    t_tick;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule